// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit CPU bus and the ROM and RAM arrays of a plug-in cartridge. The CPU sees a 32 KB ROM space and an 8 KB external RAM window. The controller turns each CPU address into a physical ROM or RAM address, using the bank registers it holds. A CPU write into the ROM space does not store data. It updates one of those bank registers instead.

A type code from the cartridge header picks one of three personalities. The first is a flat mapping with no banking. The second has a 5-bit low ROM bank, a 2-bit high register and a banking-mode flag that moves the high bits between ROM and RAM. The third has a 7-bit ROM bank, an access enable, and a window select that points either at a RAM bank or at a clock register. Clock counting happens elsewhere, so a clock register reads as zero here.

The ROM and RAM ports are synchronous. The physical addresses, the RAM write strobe and the read-source select are all registered. Read data therefore reaches the CPU one cycle after the address is presented.

Top module: `cart_bank_ctrl`

## Requirements
- R1: The type code is decoded as follows. 0x00, 0x08 and 0x09 give the flat personality. 0x01 to 0x03 give the 5+2-bit personality. 0x0F to 0x13 give the 7-bit personality. Every other code raises `unsupported` and behaves as flat.
- R2: A CPU address in 0x0000–0x3FFF gives ROM address equal to the CPU address. An address in 0x4000–0x7FFF gives bank×0x4000 + (addr − 0x4000).
- R3: A CPU address in 0xA000–0xBFFF gives RAM address ram_bank×0x2000 + (addr − 0xA000). A read at any address outside the ROM space and this window returns 0xFF.
- R4: In the flat personality, ROM 0x4000–0x7FFF uses bank 1 and the RAM window uses bank 0. Every CPU write is ignored.
- R5: In the 5+2-bit personality, a write to 0x2000–0x3FFF replaces bits [4:0] of the ROM bank and keeps bits [6:5]. A zero result in bits [4:0] is stored as 1.
- R6: In the 5+2-bit personality, a write to 0x4000–0x5FFF stores data[1:0] as the high bits, and a write to 0x6000–0x7FFF stores data[0] as the mode flag. RAM window writes reach the RAM.
- R7: In the 5+2-bit personality, mode 0 uses ROM bank {high, low5} and RAM bank 0. Mode 1 uses ROM bank low5 only and RAM bank = high.
- R8: In the 7-bit personality, writing 0x0A to 0x0000–0x1FFF enables window access and writing 0x00 disables it. Any other value leaves the enable as it was.
- R9: In the 7-bit personality, a write to 0x2000–0x3FFF sets the ROM bank to data & 0x7F, and bank 0 is allowed. Writes to 0x6000–0x7FFF change nothing.
- R10: In the 7-bit personality, writing 0x00–0x03 to 0x4000–0x5FFF selects that RAM bank, and writing 0x08–0x0C selects a clock register. While a clock register is selected, window reads return 0x00 and window writes are dropped. Any other value sets the `bankErr` flag, which stays set until reset.
- R11: After reset, the ROM bank is 1, the RAM bank, high bits and mode are 0, window access is disabled, and `bankErr` and `ramWe` are 0. In the 7-bit personality, a disabled window reads 0xFF and ignores writes.
- R12: A read presented at a clock edge has its physical address and its `cpuRdData` valid right after that edge. A window write shows on `ramWe`/`ramWrData` after the same edge and lands in RAM at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| typeCode | input | 8 | Mapper type code from the cartridge header |
| cpuAddr | input | 16 | CPU address |
| cpuWr | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Read data returned to the CPU |
| romAddr | output | ROM_AW | Registered physical ROM address |
| romRdData | input | 8 | ROM read data for romAddr |
| ramAddr | output | RAM_AW | Registered physical RAM address |
| ramWe | output | 1 | Registered RAM write enable |
| ramWrData | output | 8 | Registered RAM write data |
| ramRdData | input | 8 | RAM read data for ramAddr |
| unsupported | output | 1 | Type code not recognised |
| bankErr | output | 1 | Sticky invalid window-select flag |

## Verification
Register writes take effect at the edge where the write is sampled, so the translation of the next address already uses them. Read data and both physical addresses are due right after the edge that samples the address. The bench therefore drives every transaction at the falling edge and samples 1 ns after the next rising edge. A RAM write shows on the RAM port after one edge and lands in the modelled array at the following edge. Because of that, a read placed straight after a write to the same address observes the new value, and each bank-register write is checked by the read that follows it.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int BANK_W    = 7;
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;
  localparam int RAM_BK_W  = 2;

  typedef enum logic [1:0] {MAP_FLAT, MAP_5P2, MAP_7B} mapKind_e;
  typedef enum logic [1:0] {SRC_ROM, SRC_RAM, SRC_ZERO, SRC_OPEN} rdSrc_e;

  typedef struct packed {
    logic accOn;
    logic accOff;
    logic romLow;
    logic romAll;
    logic hiBits;
    logic modeBit;
    logic ramBank;
    logic clkReg;
    logic badSel;
  } ctrlStb_t;
endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
(
  input  logic [7:0] typeCode,
  input  logic [2:0] cpuAddrHi,
  input  logic       cpuWr,
  input  logic [7:0] cpuWrData,
  output mapKind_e   mapKind,
  output logic       unsupported,
  output ctrlStb_t   stb
);
  logic romSpaceWr;

  always_comb begin
    unsupported = 1'b0;
    unique case (typeCode)
      8'h00, 8'h08, 8'h09:                    mapKind = MAP_FLAT;
      8'h01, 8'h02, 8'h03:                    mapKind = MAP_5P2;
      8'h0F, 8'h10, 8'h11, 8'h12, 8'h13:      mapKind = MAP_7B;
      default: begin
        mapKind     = MAP_FLAT;
        unsupported = 1'b1;
      end
    endcase
  end

  assign romSpaceWr = cpuWr && !cpuAddrHi[2];

  always_comb begin
    stb = '0;
    if (romSpaceWr) begin
      if (mapKind == MAP_5P2) begin
        unique case (cpuAddrHi[1:0])
          2'b01:   stb.romLow  = 1'b1;
          2'b10:   stb.hiBits  = 1'b1;
          2'b11:   stb.modeBit = 1'b1;
          default: ;
        endcase
      end else if (mapKind == MAP_7B) begin
        unique case (cpuAddrHi[1:0])
          2'b00: begin
            stb.accOn  = (cpuWrData == 8'h0A);
            stb.accOff = (cpuWrData == 8'h00);
          end
          2'b01: stb.romAll = 1'b1;
          2'b10: begin
            if (cpuWrData <= 8'h03)                           stb.ramBank = 1'b1;
            else if (cpuWrData >= 8'h08 && cpuWrData <= 8'h0C) stb.clkReg  = 1'b1;
            else                                              stb.badSel  = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cbc_dpath.sv
module cbc_dpath
  import cbc_pkg::*;
#(
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapKind_e          mapKind,
  input  ctrlStb_t          stb,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWr,
  input  logic [7:0]        cpuWrData,
  input  logic [7:0]        romRdData,
  input  logic [7:0]        ramRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWrData,
  output logic [7:0]        cpuRdData,
  output logic              bankErr
);
  localparam int ROM_FULL_W = BANK_W + ROM_OFS_W;
  localparam int RAM_FULL_W = RAM_BK_W + RAM_OFS_W;

  logic [BANK_W-1:0]   romBank;
  logic [RAM_BK_W-1:0] hiSel, ramBank;
  logic                modeSel, clkMode, accEn;

  logic [BANK_W-1:0]     effRom;
  logic [RAM_BK_W-1:0]   effRam;
  logic [ROM_FULL_W-1:0] romFull;
  logic [RAM_FULL_W-1:0] ramFull;
  logic                  inRom, inRom0, inWin, winWrOk, weNext;
  rdSrc_e                srcNext, srcQ;
  logic [4:0]            lowIn;

  assign lowIn = cpuWrData[4:0];

  // Bank-control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank <= BANK_W'(1);
      hiSel   <= '0;
      ramBank <= '0;
      modeSel <= 1'b0;
      clkMode <= 1'b0;
      accEn   <= 1'b0;
      bankErr <= 1'b0;
    end else begin
      if (stb.romLow)  romBank <= {romBank[6:5], (lowIn == 5'd0) ? 5'd1 : lowIn};
      if (stb.romAll)  romBank <= cpuWrData[6:0];
      if (stb.hiBits)  hiSel   <= cpuWrData[1:0];
      if (stb.modeBit) modeSel <= cpuWrData[0];
      if (stb.accOn)   accEn   <= 1'b1;
      if (stb.accOff)  accEn   <= 1'b0;
      if (stb.ramBank) begin
        ramBank <= cpuWrData[1:0];
        clkMode <= 1'b0;
      end
      if (stb.clkReg)  clkMode <= 1'b1;
      if (stb.badSel)  bankErr <= 1'b1;
    end
  end

  // Effective banks per personality
  always_comb begin
    unique case (mapKind)
      MAP_5P2: begin
        effRom = modeSel ? {2'b00, romBank[4:0]} : {hiSel, romBank[4:0]};
        effRam = modeSel ? hiSel : '0;
      end
      MAP_7B: begin
        effRom = romBank;
        effRam = ramBank;
      end
      default: begin
        effRom = BANK_W'(1);
        effRam = '0;
      end
    endcase
  end

  assign inRom0  = (cpuAddr[15:14] == 2'b00);
  assign inRom   = !cpuAddr[15];
  assign inWin   = (cpuAddr[15:13] == 3'b101);
  assign romFull = {inRom0 ? '0 : effRom, cpuAddr[ROM_OFS_W-1:0]};
  assign ramFull = {effRam, cpuAddr[RAM_OFS_W-1:0]};
  assign winWrOk = (mapKind == MAP_5P2) || (mapKind == MAP_7B && accEn && !clkMode);
  assign weNext  = cpuWr && inWin && winWrOk;

  always_comb begin
    if (inRom)                              srcNext = SRC_ROM;
    else if (!inWin)                        srcNext = SRC_OPEN;
    else if (mapKind != MAP_7B)             srcNext = SRC_RAM;
    else if (!accEn)                        srcNext = SRC_OPEN;
    else if (clkMode)                       srcNext = SRC_ZERO;
    else                                    srcNext = SRC_RAM;
  end

  // Registered port side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      romAddr   <= '0;
      ramAddr   <= '0;
      ramWe     <= 1'b0;
      ramWrData <= '0;
      srcQ      <= SRC_OPEN;
    end else begin
      romAddr   <= ROM_AW'(romFull);
      ramAddr   <= RAM_AW'(ramFull);
      ramWe     <= weNext;
      ramWrData <= cpuWrData;
      srcQ      <= srcNext;
    end
  end

  always_comb begin
    unique case (srcQ)
      SRC_ROM:  cpuRdData = romRdData;
      SRC_RAM:  cpuRdData = ramRdData;
      SRC_ZERO: cpuRdData = 8'h00;
      default:  cpuRdData = 8'hFF;
    endcase
  end

  AST_ROM0_BANK0: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:14] == 2'b00) |=> (romAddr[ROM_AW-1:ROM_OFS_W] == '0)); // R2
  AST_FLAT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (mapKind == MAP_FLAT) |=> !ramWe); // R4
  AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mapKind == MAP_5P2) |-> (romBank[4:0] != 5'd0)); // R5
  AST_CLK_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mapKind == MAP_7B && accEn && clkMode && inWin) |=> (cpuRdData == 8'h00 && !ramWe)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    bankErr |=> bankErr); // R10
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (mapKind == MAP_7B && !accEn) |=> !ramWe); // R11
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        typeCode,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWr,
  input  logic [7:0]        cpuWrData,
  output logic [7:0]        cpuRdData,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romRdData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWrData,
  input  logic [7:0]        ramRdData,
  output logic              unsupported,
  output logic              bankErr
);
  mapKind_e mapKind;
  ctrlStb_t stb;

  cbc_ctrl uCtrl (
    .typeCode    (typeCode),
    .cpuAddrHi   (cpuAddr[15:13]),
    .cpuWr       (cpuWr),
    .cpuWrData   (cpuWrData),
    .mapKind     (mapKind),
    .unsupported (unsupported),
    .stb         (stb)
  );

  cbc_dpath #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .mapKind   (mapKind),
    .stb       (stb),
    .cpuAddr   (cpuAddr),
    .cpuWr     (cpuWr),
    .cpuWrData (cpuWrData),
    .romRdData (romRdData),
    .ramRdData (ramRdData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramWrData (ramWrData),
    .cpuRdData (cpuRdData),
    .bankErr   (bankErr)
  );
endmodule

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;
  localparam int ROM_AW = 21;
  localparam int RAM_AW = 15;
  localparam int NV = 53;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        typeCode = 8'h00;
  logic [15:0]       cpuAddr = '0;
  logic              cpuWr = 1'b0;
  logic [7:0]        cpuWrData = '0;
  logic [7:0]        cpuRdData, romRdData, ramRdData, ramWrData;
  logic [ROM_AW-1:0] romAddr;
  logic [RAM_AW-1:0] ramAddr;
  logic              ramWe, unsupported, bankErr;
  logic [7:0]        ramMem [0:63];

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_bank_ctrl #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) dut (
    .clk(clk), .rstN(rstN), .typeCode(typeCode), .cpuAddr(cpuAddr),
    .cpuWr(cpuWr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .romAddr(romAddr), .romRdData(romRdData), .ramAddr(ramAddr),
    .ramWe(ramWe), .ramWrData(ramWrData), .ramRdData(ramRdData),
    .unsupported(unsupported), .bankErr(bankErr)
  );

  // ROM content: bank number XOR low address byte
  assign romRdData = {1'b0, romAddr[20:14]} ^ romAddr[7:0];
  // Small RAM model: bank bits plus the low four offset bits
  assign ramRdData = ramMem[{ramAddr[14:13], ramAddr[3:0]}];
  always @(posedge clk) if (ramWe) ramMem[{ramAddr[14:13], ramAddr[3:0]}] <= ramWrData;

  // {type, wr, addr, wdata, expected read, requirement}
  localparam logic [48:0] VECS [0:NV-1] = '{
    {8'h00, 1'b0, 16'h0105, 8'h00, 8'h05, 8'd4},  // R4 bank 0 direct
    {8'h00, 1'b0, 16'h4000, 8'h00, 8'h01, 8'd4},  // R4 fixed bank 1
    {8'h00, 1'b1, 16'h2000, 8'h05, 8'h00, 8'd0},
    {8'h00, 1'b0, 16'h4000, 8'h00, 8'h01, 8'd4},  // R4 bank write ignored
    {8'h00, 1'b1, 16'hA002, 8'h77, 8'h00, 8'd0},
    {8'h00, 1'b0, 16'hA002, 8'h00, 8'h00, 8'd4},  // R4 RAM write ignored
    {8'h00, 1'b0, 16'h8000, 8'h00, 8'hFF, 8'd3},  // R3 unmapped
    {8'h01, 1'b0, 16'h4000, 8'h00, 8'h01, 8'd11}, // R11 reset bank
    {8'h01, 1'b1, 16'h2000, 8'h00, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'h4000, 8'h00, 8'h01, 8'd5},  // R5 zero remap
    {8'h01, 1'b1, 16'h2000, 8'h13, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'h4000, 8'h00, 8'h13, 8'd5},  // R5
    {8'h01, 1'b1, 16'h2000, 8'hE5, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'h4007, 8'h00, 8'h02, 8'd5},  // R5 upper data bits dropped
    {8'h01, 1'b1, 16'h4000, 8'hFE, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'h4000, 8'h00, 8'h45, 8'd7},  // R7 mode 0 high bits
    {8'h01, 1'b1, 16'h2000, 8'h20, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'h4000, 8'h00, 8'h41, 8'd5},  // R5 0x40 -> 0x41
    {8'h01, 1'b1, 16'hA003, 8'h5A, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'hA003, 8'h00, 8'h5A, 8'd3},  // R3 RAM bank 0
    {8'h01, 1'b1, 16'h6000, 8'h03, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'h4000, 8'h00, 8'h01, 8'd7},  // R7 mode 1 ROM
    {8'h01, 1'b0, 16'hA003, 8'h00, 8'h00, 8'd7},  // R7 mode 1 RAM bank 2
    {8'h01, 1'b1, 16'hA003, 8'h66, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'hA003, 8'h00, 8'h66, 8'd6},  // R6
    {8'h01, 1'b1, 16'h6000, 8'h00, 8'h00, 8'd0},
    {8'h01, 1'b0, 16'hA003, 8'h00, 8'h5A, 8'd6},  // R6 mode back to 0
    {8'h01, 1'b0, 16'h0005, 8'h00, 8'h05, 8'd2},  // R2
    {8'h11, 1'b0, 16'hA000, 8'h00, 8'hFF, 8'd11}, // R11 disabled read
    {8'h11, 1'b1, 16'hA000, 8'h12, 8'h00, 8'd0},
    {8'h11, 1'b1, 16'h0000, 8'h0A, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA000, 8'h00, 8'h00, 8'd11}, // R11 disabled write dropped
    {8'h11, 1'b1, 16'hA000, 8'h34, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA000, 8'h00, 8'h34, 8'd8},  // R8
    {8'h11, 1'b1, 16'h1FFF, 8'h55, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA000, 8'h00, 8'h34, 8'd8},  // R8 other value keeps enable
    {8'h11, 1'b1, 16'h0000, 8'h00, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA000, 8'h00, 8'hFF, 8'd8},  // R8 disable
    {8'h11, 1'b1, 16'h0000, 8'h0A, 8'h00, 8'd0},
    {8'h11, 1'b1, 16'h2000, 8'h00, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'h4000, 8'h00, 8'h00, 8'd9},  // R9 bank 0 allowed
    {8'h11, 1'b1, 16'h3FFF, 8'hFF, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'h4000, 8'h00, 8'h7F, 8'd9},  // R9 masked
    {8'h11, 1'b1, 16'h6000, 8'h01, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'h4000, 8'h00, 8'h7F, 8'd9},  // R9 latch no effect
    {8'h11, 1'b1, 16'h4000, 8'h03, 8'h00, 8'd0},
    {8'h11, 1'b1, 16'hA001, 8'h99, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA001, 8'h00, 8'h99, 8'd10}, // R10 RAM bank 3
    {8'h11, 1'b1, 16'h4000, 8'h09, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA001, 8'h00, 8'h00, 8'd10}, // R10 clock reads zero
    {8'h11, 1'b1, 16'hA001, 8'h11, 8'h00, 8'd0},
    {8'h11, 1'b1, 16'h4000, 8'h03, 8'h00, 8'd0},
    {8'h11, 1'b0, 16'hA001, 8'h00, 8'h99, 8'd10}  // R10 clock write dropped
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [7:0] typ);
    @(negedge clk);
    rstN = 1'b0; cpuWr = 1'b0; typeCode = typ;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cyc(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWr = wr; cpuAddr = a; cpuWrData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 64; k++) ramMem[k] = 8'h00;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || VECS[i][48:41] != VECS[i-1][48:41]) doReset(VECS[i][48:41]);
      cyc(VECS[i][40], VECS[i][39:24], VECS[i][23:16]);
      if (!VECS[i][40]) check(int'(VECS[i][7:0]), 32'(cpuRdData), 32'(VECS[i][15:8]));
    end

    // R1 type decode, checked while held in reset
    @(negedge clk); rstN = 1'b0;
    typeCode = 8'h20; #1 check(1, 32'(unsupported), 32'd1);
    typeCode = 8'h13; #1 check(1, 32'(unsupported), 32'd0);
    typeCode = 8'h14; #1 check(1, 32'(unsupported), 32'd1);
    typeCode = 8'h08; #1 check(1, 32'(unsupported), 32'd0);
    typeCode = 8'h04; #1 check(1, 32'(unsupported), 32'd1);

    // R11 reset state
    doReset(8'h11);
    #1;
    check(11, 32'(bankErr), 32'd0);
    check(11, 32'(ramWe), 32'd0);
    check(1, 32'(unsupported), 32'd0);

    // R2 and R3 physical address translation, R12 timing
    cyc(1'b1, 16'h0000, 8'h0A);
    cyc(1'b1, 16'h2000, 8'h7F);
    cyc(1'b1, 16'h4000, 8'h03);
    cyc(1'b0, 16'h5234, 8'h00);
    check(2, 32'(romAddr), 32'h1FD234);
    check(12, 32'(cpuRdData), 32'h7F ^ 32'h34);
    cyc(1'b0, 16'hB456, 8'h00);
    check(3, 32'(ramAddr), 32'h7456);
    cyc(1'b1, 16'hA00C, 8'hAB);
    check(12, 32'(ramWe), 32'd1);
    check(12, 32'(ramWrData), 32'hAB);
    cyc(1'b0, 16'hA00C, 8'h00);
    check(12, 32'(ramWe), 32'd0);
    check(12, 32'(cpuRdData), 32'hAB);

    // R10 sticky error flag
    cyc(1'b1, 16'h4000, 8'h05);
    check(10, 32'(bankErr), 32'd1);
    cyc(1'b1, 16'h4000, 8'h00);
    check(10, 32'(bankErr), 32'd1);
    cyc(1'b0, 16'hA00C, 8'h00);
    check(10, 32'(cpuRdData), 32'h00);

    finishRun();
  end
endmodule